// File: doc/BRIEF.md
# Segmented Address Translation Unit

This unit turns a virtual address into a physical address using a small table of segment descriptors. The two most significant bits of the virtual address choose one of three segments: code, heap and stack. The fourth selector value has no segment behind it. The remaining bits are an offset into the chosen segment. Each segment has a base, a limit (its size in bytes), a read-only flag, a privilege level and a usable/type flag.

Every request is checked against the selected segment, and the checks run in a fixed priority order: the selector is valid and the segment is usable, then privilege, then write protection, then the bound. A request that passes all four returns the base plus the offset. A request that fails any check returns a fault with a cause code, and the physical address is zero.

Requests and responses use a valid/ready handshake with one cycle of registered latency. A separate write port loads one descriptor per cycle.

Top module: `seg_xlate_unit`

## Requirements
- R1: The selector is bits [VA_W-1:VA_W-2] of `req_addr` and the offset is bits [VA_W-3:0]. With no fault, `rsp_paddr` equals the selected base plus the zero-extended offset, taken modulo 2^PA_W.
- R2: An offset greater than or equal to the selected segment's 20-bit limit gives cause 1 (bound). An offset equal to limit-1 passes.
- R3: A request with `req_write`=1 to a segment whose read-only flag is 1 gives cause 2 (protection). A read of that segment is not affected by the flag.
- R4: A request whose `req_cpl` is numerically greater than the segment's privilege level gives cause 3 (privilege). Level 0 is the most privileged.
- R5: Selector value 3, or a segment whose type flag is 0 (system, unusable), gives cause 4 (invalid segment). Cause 0 means no fault.
- R6: When several checks fail together, the cause reported is the first in this order: invalid segment, privilege, protection, bound.
- R7: `req_ready` equals `!rsp_valid || rsp_ready`. A request accepted at one clock edge is presented on `rsp_valid` after that edge. While `rsp_valid`=1 and `rsp_ready`=0, every response output holds its value.
- R8: Reset clears all descriptors, so every request faults with cause 4 until its segment is loaded. A write with `cfg_we`=1 and `cfg_sel` 0..2 replaces that descriptor. A write with `cfg_sel`=3 changes nothing.
- R9: A request accepted in the same cycle as a descriptor write uses the old descriptor. Later requests use the new one.
- R10: `rsp_fault` is 1 exactly when `rsp_cause` is non-zero, and `rsp_paddr` is 0 whenever `rsp_fault` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_sel | input | 2 | Segment to write |
| cfg_base | input | 32 | Segment base address |
| cfg_limit | input | 20 | Segment size in bytes |
| cfg_dpl | input | 2 | Segment privilege level |
| cfg_usable | input | 1 | Type flag: 1 code/data, 0 system |
| cfg_rd_only | input | 1 | Writes fault when 1 |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with valid |
| req_addr | input | VA_W | Virtual address |
| req_write | input | 1 | 1 for a store access |
| req_cpl | input | 2 | Current privilege level |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer accepts the response |
| rsp_paddr | output | PA_W | Physical address, 0 on fault |
| rsp_fault | output | 1 | Translation failed |
| rsp_cause | output | 3 | 0 none, 1 bound, 2 protection, 3 privilege, 4 invalid segment |

## Verification
Directed requests cover the following cases:
- Offsets at 0, at limit-1 and at the limit, which separate a correct bound compare from an off-by-one.
- Reads and writes to a read-only segment, which separate the protection check from the access type.
- Privilege levels just above and just below the segment's level.
- Combined failures, which expose the priority order.

A selector-3 write followed by a read of segment 0 shows whether the ignored write aliased into a real slot. A descriptor write in the same cycle as a request tells old-descriptor use apart from bypass. Long stalls test response holding and backpressure. Seeded random traffic then mixes descriptors, offsets near each limit, access types and back-pressure.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    localparam int unsigned SEG_BASE_W = 32;
    localparam int unsigned SEG_LIM_W  = 20;
    localparam int unsigned SEG_PL_W   = 2;
    localparam int unsigned SEG_COUNT  = 3;
    localparam int unsigned SEG_SEL_W  = 2;

    // Fault causes; encoding is visible at the top-level port
    typedef enum logic [2:0] {
        FLT_NONE   = 3'd0,
        FLT_BOUND  = 3'd1,
        FLT_PROT   = 3'd2,
        FLT_PRIV   = 3'd3,
        FLT_BADSEG = 3'd4
    } flt_cause_e;

    typedef struct packed {
        logic [SEG_BASE_W-1:0] base;
        logic [SEG_LIM_W-1:0]  limit;
        logic [SEG_PL_W-1:0]   dpl;
        logic                  usable;
        logic                  rd_only;
    } seg_desc_t;

endpackage

// File: rtl/seg_desc_file.sv
module seg_desc_file
    import seg_xlate_pkg::*;
#(
    parameter int unsigned N_SEG = SEG_COUNT,
    parameter int unsigned SEL_W = SEG_SEL_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic [SEL_W-1:0] wr_sel_i,
    input  seg_desc_t        wr_desc_i,
    output seg_desc_t        desc_o [N_SEG]
);

    seg_desc_t tbl_d [N_SEG];
    seg_desc_t tbl_q [N_SEG];

    // Next-state: only the addressed slot changes; out-of-range selectors hit nothing
    always_comb begin
        for (int i = 0; i < int'(N_SEG); i++) begin
            tbl_d[i] = tbl_q[i];
            if (wr_en_i && (wr_sel_i == SEL_W'(i))) begin
                tbl_d[i] = wr_desc_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < int'(N_SEG); i++) begin
                tbl_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < int'(N_SEG); i++) begin
                tbl_q[i] <= tbl_d[i];
            end
        end
    end

    for (genvar g = 0; g < int'(N_SEG); g++) begin : g_slot
        assign desc_o[g] = tbl_q[g];

        // R8: an addressed write lands in its slot
        a_r8_slot_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (wr_en_i && (wr_sel_i == SEL_W'(g))) |=> (tbl_q[g] == $past(wr_desc_i)));

        // R8: any other write (including the unused selector) leaves the slot alone
        a_r8_slot_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !(wr_en_i && (wr_sel_i == SEL_W'(g))) |=> $stable(tbl_q[g]));
    end

endmodule

// File: rtl/seg_check.sv
module seg_check
    import seg_xlate_pkg::*;
#(
    parameter int unsigned VA_W  = 32,
    parameter int unsigned PA_W  = 32,
    parameter int unsigned N_SEG = SEG_COUNT,
    parameter int unsigned SEL_W = SEG_SEL_W
) (
    input  logic [VA_W-1:0]     addr_i,
    input  logic                wr_i,
    input  logic [SEG_PL_W-1:0] cpl_i,
    input  seg_desc_t           desc_i [N_SEG],
    output logic [PA_W-1:0]     paddr_o,
    output flt_cause_e          cause_o
);

    localparam int unsigned OFF_W = VA_W - SEL_W;
    localparam int unsigned CMP_W = (OFF_W > SEG_LIM_W) ? OFF_W : SEG_LIM_W;

    logic [SEL_W-1:0] sel;
    logic [OFF_W-1:0] off;
    seg_desc_t        pick;
    logic             hit;
    logic             out_of_bound;

    // Segment select and offset split
    always_comb begin
        sel  = addr_i[VA_W-1 -: SEL_W];
        off  = addr_i[OFF_W-1:0];
        pick = '0;
        hit  = 1'b0;
        for (int i = 0; i < int'(N_SEG); i++) begin
            if (sel == SEL_W'(i)) begin
                pick = desc_i[i];
                hit  = 1'b1;
            end
        end
        out_of_bound = (CMP_W'(off) >= CMP_W'(pick.limit));
    end

    // Fixed priority: invalid > privilege > protection > bound
    always_comb begin
        if (!hit || !pick.usable) begin
            cause_o = FLT_BADSEG;
        end else if (cpl_i > pick.dpl) begin
            cause_o = FLT_PRIV;
        end else if (wr_i && pick.rd_only) begin
            cause_o = FLT_PROT;
        end else if (out_of_bound) begin
            cause_o = FLT_BOUND;
        end else begin
            cause_o = FLT_NONE;
        end
        paddr_o = (cause_o == FLT_NONE) ? (PA_W'(pick.base) + PA_W'(off)) : '0;
    end

endmodule

// File: rtl/seg_rsp_stage.sv
module seg_rsp_stage
    import seg_xlate_pkg::*;
#(
    parameter int unsigned PA_W = 32
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            take_i,
    input  logic [PA_W-1:0] paddr_i,
    input  flt_cause_e      cause_i,
    input  logic            out_ready_i,
    output logic            in_ready_o,
    output logic            out_valid_o,
    output logic [PA_W-1:0] out_paddr_o,
    output logic            out_fault_o,
    output flt_cause_e      out_cause_o
);

    typedef struct packed {
        logic            valid;
        logic            fault;
        flt_cause_e      cause;
        logic [PA_W-1:0] paddr;
    } rsp_t;

    rsp_t rsp_d;
    rsp_t rsp_q;

    assign in_ready_o = !rsp_q.valid || out_ready_i;

    always_comb begin
        rsp_d = rsp_q;
        if (take_i) begin
            rsp_d.valid = 1'b1;
            rsp_d.fault = (cause_i != FLT_NONE);
            rsp_d.cause = cause_i;
            rsp_d.paddr = paddr_i;
        end else if (out_ready_i) begin
            rsp_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign out_valid_o = rsp_q.valid;
    assign out_paddr_o = rsp_q.paddr;
    assign out_fault_o = rsp_q.fault;
    assign out_cause_o = rsp_q.cause;

    // R7: a stalled response keeps every field
    a_r7_hold_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o && !out_ready_i) |=>
            (out_valid_o && $stable(out_paddr_o) && $stable(out_cause_o) && $stable(out_fault_o)));

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
    import seg_xlate_pkg::*;
#(
    parameter int unsigned VA_W = 32,
    parameter int unsigned PA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [SEG_SEL_W-1:0]  cfg_sel,
    input  logic [SEG_BASE_W-1:0] cfg_base,
    input  logic [SEG_LIM_W-1:0]  cfg_limit,
    input  logic [SEG_PL_W-1:0]   cfg_dpl,
    input  logic                  cfg_usable,
    input  logic                  cfg_rd_only,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [VA_W-1:0]       req_addr,
    input  logic                  req_write,
    input  logic [SEG_PL_W-1:0]   req_cpl,
    output logic                  rsp_valid,
    input  logic                  rsp_ready,
    output logic [PA_W-1:0]       rsp_paddr,
    output logic                  rsp_fault,
    output logic [2:0]            rsp_cause
);

    seg_desc_t  wr_desc;
    seg_desc_t  tbl [SEG_COUNT];
    logic [PA_W-1:0] chk_paddr;
    flt_cause_e chk_cause;
    flt_cause_e out_cause;
    logic       accept;

    always_comb begin
        wr_desc.base    = cfg_base;
        wr_desc.limit   = cfg_limit;
        wr_desc.dpl     = cfg_dpl;
        wr_desc.usable  = cfg_usable;
        wr_desc.rd_only = cfg_rd_only;
    end

    seg_desc_file #(
        .N_SEG (SEG_COUNT),
        .SEL_W (SEG_SEL_W)
    ) desc_file_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .wr_en_i   (cfg_we),
        .wr_sel_i  (cfg_sel),
        .wr_desc_i (wr_desc),
        .desc_o    (tbl)
    );

    seg_check #(
        .VA_W  (VA_W),
        .PA_W  (PA_W),
        .N_SEG (SEG_COUNT),
        .SEL_W (SEG_SEL_W)
    ) check_i (
        .addr_i  (req_addr),
        .wr_i    (req_write),
        .cpl_i   (req_cpl),
        .desc_i  (tbl),
        .paddr_o (chk_paddr),
        .cause_o (chk_cause)
    );

    assign accept = req_valid && req_ready;

    seg_rsp_stage #(
        .PA_W (PA_W)
    ) rsp_stage_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .take_i      (accept),
        .paddr_i     (chk_paddr),
        .cause_i     (chk_cause),
        .out_ready_i (rsp_ready),
        .in_ready_o  (req_ready),
        .out_valid_o (rsp_valid),
        .out_paddr_o (rsp_paddr),
        .out_fault_o (rsp_fault),
        .out_cause_o (out_cause)
    );

    assign rsp_cause = out_cause;

    // R7: every accepted request yields a response on the next cycle
    a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> rsp_valid);

    // R7: backpressure blocks new requests
    a_r7_block_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |-> !req_ready);

    // R5: the unused selector always reports an invalid segment
    a_r5_unused_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (req_addr[VA_W-1 -: SEG_SEL_W] == 2'd3)) |=>
            (rsp_fault && (rsp_cause == 3'd4)));

    // R10: a faulting response carries no address
    a_r10_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

    // R10: fault flag agrees with the cause code
    a_r10_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_fault == (rsp_cause != 3'd0)));

endmodule

// File: tb/seg_xlate_unit_tb_top.sv
`timescale 1ns/1ps
module seg_xlate_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_base = '0;
    logic [19:0] cfg_limit = '0;
    logic [1:0]  cfg_dpl = '0;
    logic        cfg_usable = 1'b0;
    logic        cfg_rd_only = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [1:0]  req_cpl = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [31:0] rsp_paddr;
    logic        rsp_fault;
    logic [2:0]  rsp_cause;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench model of the descriptor table
    logic [31:0] m_base [3];
    logic [19:0] m_lim  [3];
    logic [1:0]  m_dpl  [3];
    logic        m_use  [3];
    logic        m_ro   [3];

    logic [34:0] exp_q [$];
    string       tag_q [$];
    string       cur_tag = "";

    always #2 clk = ~clk;

    seg_xlate_unit dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_sel     (cfg_sel),
        .cfg_base    (cfg_base),
        .cfg_limit   (cfg_limit),
        .cfg_dpl     (cfg_dpl),
        .cfg_usable  (cfg_usable),
        .cfg_rd_only (cfg_rd_only),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_addr    (req_addr),
        .req_write   (req_write),
        .req_cpl     (req_cpl),
        .rsp_valid   (rsp_valid),
        .rsp_ready   (rsp_ready),
        .rsp_paddr   (rsp_paddr),
        .rsp_fault   (rsp_fault),
        .rsp_cause   (rsp_cause)
    );

    // Expected {cause, paddr} from the requirements
    function automatic logic [34:0] expect_fn(logic [31:0] a, logic wr, logic [1:0] cpl);
        logic [1:0]  s;
        logic [29:0] o;
        logic [2:0]  c;
        logic [31:0] p;
        s = a[31:30];
        o = a[29:0];
        if (s == 2'd3)                   c = 3'd4;
        else if (!m_use[s])              c = 3'd4;
        else if (cpl > m_dpl[s])         c = 3'd3;
        else if (wr && m_ro[s])          c = 3'd2;
        else if (o >= {10'd0, m_lim[s]}) c = 3'd1;
        else                             c = 3'd0;
        if (c == 3'd0) p = m_base[s] + {2'b00, o};
        else           p = 32'd0;
        return {c, p};
    endfunction

    function automatic string tag_of(logic [2:0] c);
        case (c)
            3'd0:    return "R1";
            3'd1:    return "R2";
            3'd2:    return "R3";
            3'd3:    return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Inputs were driven just after a negedge; evaluate this cycle, then move on
    task automatic step();
        logic [34:0] e;
        string t;
        #1;
        check(req_ready === (!rsp_valid || rsp_ready), "R7", "req_ready",
              64'(req_ready), 64'(!rsp_valid || rsp_ready));
        if (rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7", "unexpected response", 64'(rsp_valid), 64'd0);
            end else begin
                e = exp_q[0];
                t = tag_q[0];
                check(rsp_paddr === e[31:0], t, "paddr", 64'(rsp_paddr), 64'(e[31:0]));
                check(rsp_cause === e[34:32], t, "cause", 64'(rsp_cause), 64'(e[34:32]));
                check(rsp_fault === (e[34:32] != 3'd0), "R10", "fault flag",
                      64'(rsp_fault), 64'(e[34:32] != 3'd0));
                if (rsp_ready) begin
                    void'(exp_q.pop_front());
                    void'(tag_q.pop_front());
                end
            end
        end
        if (req_valid && req_ready) begin
            e = expect_fn(req_addr, req_write, req_cpl);
            exp_q.push_back(e);
            tag_q.push_back((cur_tag != "") ? cur_tag : tag_of(e[34:32]));
        end
        if (cfg_we && cfg_sel < 2'd3) begin
            m_base[cfg_sel] = cfg_base;
            m_lim[cfg_sel]  = cfg_limit;
            m_dpl[cfg_sel]  = cfg_dpl;
            m_use[cfg_sel]  = cfg_usable;
            m_ro[cfg_sel]   = cfg_rd_only;
        end
        @(negedge clk);
    endtask

    task automatic load(logic [1:0] s, logic [31:0] b, logic [19:0] l, logic [1:0] d,
                        logic u, logic r);
        cfg_we = 1'b1; cfg_sel = s; cfg_base = b; cfg_limit = l;
        cfg_dpl = d; cfg_usable = u; cfg_rd_only = r;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic access(logic [1:0] s, logic [29:0] o, logic wr, logic [1:0] cpl, string t);
        cur_tag = t;
        req_valid = 1'b1; req_addr = {s, o}; req_write = wr; req_cpl = cpl;
        rsp_ready = 1'b1;
        step();
        req_valid = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 3; i++) begin
            m_base[i] = '0; m_lim[i] = '0; m_dpl[i] = '0; m_use[i] = 1'b0; m_ro[i] = 1'b0;
        end
        void'($urandom(32'd20240611));
        @(negedge clk);
        @(negedge clk);
        // Reset state: no response pending
        check(rsp_valid === 1'b0, "R7", "reset rsp_valid", 64'(rsp_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: cleared descriptors make every segment invalid
        access(2'd0, 30'h10, 1'b0, 2'd0, "R8");
        access(2'd2, 30'h0, 1'b0, 2'd0, "R8");

        load(2'd0, 32'h1000_0000, 20'h00100, 2'd3, 1'b1, 1'b0);
        load(2'd1, 32'h2000_0000, 20'hFFFFF, 2'd0, 1'b1, 1'b1);
        load(2'd2, 32'h8000_0000, 20'h00040, 2'd3, 1'b1, 1'b1);

        // R1: base plus offset
        access(2'd0, 30'h10, 1'b0, 2'd3, "R1");
        access(2'd0, 30'h0, 1'b1, 2'd0, "R1");
        // R2: limit-1 passes, limit faults
        access(2'd0, 30'hFF, 1'b0, 2'd3, "R2");
        access(2'd0, 30'h100, 1'b0, 2'd3, "R2");
        access(2'd0, 30'h3FFF_FFFF, 1'b0, 2'd3, "R2");
        // R3: reads of a read-only segment pass, writes fault
        access(2'd2, 30'h20, 1'b0, 2'd3, "R3");
        access(2'd2, 30'h20, 1'b1, 2'd3, "R3");
        // R4: privilege
        access(2'd1, 30'h40, 1'b0, 2'd1, "R4");
        access(2'd1, 30'h40, 1'b0, 2'd0, "R4");
        // R5: unused selector
        access(2'd3, 30'h5, 1'b0, 2'd0, "R5");
        // R6: priority among simultaneous failures
        access(2'd2, 30'h50, 1'b1, 2'd3, "R6");       // protection over bound
        access(2'd1, 30'h3FFF_FFFF, 1'b1, 2'd3, "R6"); // privilege over both
        access(2'd3, 30'h0, 1'b1, 2'd3, "R6");        // invalid over all

        // R8: a write to selector 3 must not alias into a real slot
        load(2'd3, 32'hDEAD_0000, 20'h00001, 2'd0, 1'b0, 1'b1);
        access(2'd0, 30'h10, 1'b0, 2'd3, "R8");
        access(2'd1, 30'h10, 1'b0, 2'd0, "R8");
        access(2'd2, 30'h10, 1'b0, 2'd3, "R8");

        // R9: same-cycle write uses the old descriptor, later uses the new one
        cur_tag = "R9";
        cfg_we = 1'b1; cfg_sel = 2'd0; cfg_base = 32'h3000_0000; cfg_limit = 20'h00100;
        cfg_dpl = 2'd3; cfg_usable = 1'b1; cfg_rd_only = 1'b0;
        req_valid = 1'b1; req_addr = {2'd0, 30'h8}; req_write = 1'b0; req_cpl = 2'd3;
        step();
        cfg_we = 1'b0;
        step();
        req_valid = 1'b0;

        // R7: stall holds the response and blocks requests
        cur_tag = "R7";
        rsp_ready = 1'b0;
        req_valid = 1'b1; req_addr = {2'd0, 30'h4}; req_write = 1'b0; req_cpl = 2'd3;
        step();
        req_addr = {2'd0, 30'h200};
        step();
        step();
        step();
        rsp_ready = 1'b1;
        step();
        req_valid = 1'b0;
        step();
        check(exp_q.size() == 0, "R7", "drain after stall", 64'(exp_q.size()), 64'd0);

        // Seeded random traffic
        cur_tag = "";
        for (int n = 0; n < 4000; n++) begin
            logic [1:0]  s;
            logic [29:0] o;
            cfg_we = ($urandom % 8) == 0;
            cfg_sel = 2'($urandom % 4);
            cfg_base = $urandom;
            cfg_limit = (($urandom % 2) == 0) ? 20'($urandom) : 20'($urandom % 256);
            cfg_dpl = 2'($urandom % 4);
            cfg_usable = ($urandom % 8) != 0;
            cfg_rd_only = 1'($urandom % 2);
            s = 2'($urandom % 4);
            case ($urandom % 4)
                0: o = 30'($urandom);
                1: o = (s < 2'd3) ? 30'(m_lim[s]) - 30'd1 : 30'($urandom);
                2: o = (s < 2'd3) ? 30'(m_lim[s]) : 30'($urandom);
                default: o = 30'($urandom % 64);
            endcase
            req_valid = ($urandom % 4) != 0;
            req_addr = {s, o};
            req_write = 1'($urandom % 2);
            req_cpl = 2'($urandom % 4);
            rsp_ready = ($urandom % 4) != 0;
            step();
        end
        cfg_we = 1'b0;
        req_valid = 1'b0;
        rsp_ready = 1'b1;
        step();
        step();
        check(exp_q.size() == 0, "R7", "drain at end", 64'(exp_q.size()), 64'd0);

        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule